// File: doc/BRIEF.md
# Consumer Clock Selector with Coded Divider

This block drives a bank of consumer tick outputs from one shared control register. Each consumer has a 5-bit field. The field picks one input source: either an auxiliary root tick or one of several generator ticks. It also picks a small division ratio through a 2-bit code, or parks the consumer in a disabled state. All logic runs on a single system clock. The sources arrive as one-cycle tick strobes, and each consumer produces one-cycle tick strobes.

Software writes the whole register and reads it back. A command port acts on one consumer at a time, with three operations:
- switch the consumer off;
- switch it back on, using the source it last had;
- request a ratio in plain numbers. The block translates the ratio into the divide code that this build supports.

A build-time parameter picks between two divide tables. The extended table adds a divide-by-3 setting. A source or ratio change never cuts a division period short. Switching a consumer off silences it at once.

Top module: `clk_consumer_sel`

## Requirements
- R1: Consumer i owns register bits [5i+4:5i]. Bits [1:0] of the field are the divide code and bits [4:2] are the source select. A register write replaces all fields, the read port returns the register in the cycle after the write, and reset clears the register to zero.
- R2: Source select 1 routes the auxiliary tick. Values 2 to 7 route generator ticks 0 to 5. Value 0 means disabled.
- R3: With EXT_DIV=0, divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2, counted in ticks of the selected source.
- R4: With EXT_DIV=1, divide codes 0, 1, 2 and 3 give ratios 1, 4, 3 and 2.
- R5: At a ratio of N, a consumer emits exactly one output tick for every N selected input ticks, on the Nth tick.
- R6: cons_en[i] is 1 exactly when the source select of field i is nonzero, and it follows the register with the same timing.
- R7: Command op 0 (off) clears the source select of consumer cmd_idx. That consumer then emits no ticks, and any partly counted period is dropped.
- R8: Command op 1 (on) writes back the last nonzero source select the consumer held. If none has been held since reset, it writes 1. The divide code is kept.
- R9: Command op 2 (ratio) takes cmd_ratio values 1, 2, 3 and 4 and sets codes 0, 3, 1 and 1 in the default table, or codes 0, 3, 2 and 1 in the extended table. Any other cmd_ratio value leaves the code unchanged. Op 3 does nothing.
- R10: A change of source or divide code made while a period is partly counted takes effect only after that period completes.
- R11: When a register write and a command land in the same cycle, the command wins for the field bits it edits. The write sets every other bit.
- R12: An output tick appears one clock after the input tick that completes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 30 | Register write data, 5 bits per consumer |
| reg_rdata | output | 30 | Current register contents |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 off, 1 on, 2 ratio, 3 no-op |
| cmd_idx | input | 3 | Consumer addressed by the command |
| cmd_ratio | input | 3 | Requested ratio for op 2 |
| aux_tick | input | 1 | Auxiliary root tick strobe |
| gen_tick | input | 6 | Generator tick strobes |
| cons_tick | output | 6 | Consumer output tick strobes |
| cons_en | output | 6 | Per-consumer enabled status |

## Verification
The case where two functions meet in one cycle is a full register write and a single-consumer command arriving together. The bench provokes it three ways: an off command alongside a write that gives the same consumer a new source, an on command alongside such a write, and a ratio command alongside a write carrying a different code. Each result is judged from the read-back register against the rule that the command owns only the bits it edits. A second collision is a reprogram in the middle of a period. It is judged by counting output ticks over a window that straddles the change; the count only comes out right if the old ratio finishes its period first.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int FIELD_W = 5;
  localparam int CODE_W  = 2;
  localparam int SRC_W   = 3;
  localparam int CNT_W   = 3;

  typedef enum logic [1:0] {
    OP_OFF   = 2'd0,
    OP_ON    = 2'd1,
    OP_RATIO = 2'd2,
    OP_NOP   = 2'd3
  } csel_op_e;

  // Ratio selected by a divide code; the extended table turns code 2 into /3.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] code,
                                                input logic ext);
    case (code)
      2'd0:    ratio_of = 3'd1;
      2'd1:    ratio_of = 3'd4;
      2'd2:    ratio_of = ext ? 3'd3 : 3'd1;
      default: ratio_of = 3'd2;
    endcase
  endfunction

  // Code for a plain ratio request; /3 falls back to /4 without the extended table.
  function automatic logic [CODE_W-1:0] code_for(input logic [CNT_W-1:0] r,
                                                 input logic ext,
                                                 input logic [CODE_W-1:0] keep);
    case (r)
      3'd1:    code_for = 2'd0;
      3'd2:    code_for = 2'd3;
      3'd3:    code_for = ext ? 2'd2 : 2'd1;
      3'd4:    code_for = 2'd1;
      default: code_for = keep;
    endcase
  endfunction

endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
  import csel_pkg::*;
#(
  parameter int N_CONS  = 6,
  parameter bit EXT_DIV = 1'b0,
  localparam int REG_W  = N_CONS * FIELD_W,
  localparam int IDX_W  = (N_CONS > 1) ? $clog2(N_CONS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [CNT_W-1:0] cmd_ratio,
  output logic [REG_W-1:0] cfg_q,
  output logic [N_CONS-1:0] en_q
);

  logic [SRC_W-1:0] last_q [N_CONS];
  logic [REG_W-1:0] cfg_d;
  csel_op_e         op;

  assign op = csel_op_e'(cmd_op);

  always_comb begin
    cfg_d = reg_we ? reg_wdata : cfg_q;
    for (int i = 0; i < N_CONS; i++) begin
      if (cmd_valid && (cmd_idx == IDX_W'(i))) begin
        case (op)
          OP_OFF:   cfg_d[i*FIELD_W+CODE_W +: SRC_W] = '0;
          OP_ON:    cfg_d[i*FIELD_W+CODE_W +: SRC_W] = last_q[i];
          OP_RATIO: cfg_d[i*FIELD_W +: CODE_W] =
                      code_for(cmd_ratio, EXT_DIV, cfg_d[i*FIELD_W +: CODE_W]);
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      en_q  <= '0;
      for (int i = 0; i < N_CONS; i++) last_q[i] <= SRC_W'(1);
    end else begin
      cfg_q <= cfg_d;
      for (int i = 0; i < N_CONS; i++) begin
        en_q[i] <= |cfg_d[i*FIELD_W+CODE_W +: SRC_W];
        if (|cfg_d[i*FIELD_W+CODE_W +: SRC_W])
          last_q[i] <= cfg_d[i*FIELD_W+CODE_W +: SRC_W];
      end
    end
  end

  for (genvar g = 0; g < N_CONS; g++) begin : g_chk
    AST_EN_TRACKS_SRC: assert property (@(posedge clk) disable iff (rst)
      en_q[g] == (|cfg_q[g*FIELD_W+CODE_W +: SRC_W])); // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == 2'd0 && cmd_idx == IDX_W'(g)) |=> !en_q[g]); // R7
    AST_ON_RESTORES: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == 2'd1 && cmd_idx == IDX_W'(g)) |=> en_q[g]); // R8
  end

endmodule

// File: rtl/csel_channel.sv
module csel_channel
  import csel_pkg::*;
#(
  parameter int N_GEN   = 6,
  parameter bit EXT_DIV = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aux_tick,
  input  logic [N_GEN-1:0]  gen_tick,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic [CODE_W-1:0] cfg_code,
  output logic              out_tick
);

  logic [SRC_W-1:0]  act_src_q, eff_src;
  logic [CODE_W-1:0] act_code_q, eff_code;
  logic [CNT_W-1:0]  cnt_q, eff_ratio;
  logic              sel_tick;

  // Off wins at once; otherwise new settings are taken only at a period start.
  always_comb begin
    if (cfg_src == '0) begin
      eff_src  = '0;
      eff_code = cfg_code;
    end else if (cnt_q == '0) begin
      eff_src  = cfg_src;
      eff_code = cfg_code;
    end else begin
      eff_src  = act_src_q;
      eff_code = act_code_q;
    end
    eff_ratio = ratio_of(eff_code, EXT_DIV);
  end

  always_comb begin
    sel_tick = (eff_src == SRC_W'(1)) && aux_tick;
    for (int k = 0; k < N_GEN; k++)
      if (int'(eff_src) == k + 2) sel_tick = gen_tick[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_src_q  <= '0;
      act_code_q <= '0;
      cnt_q      <= '0;
      out_tick   <= 1'b0;
    end else begin
      act_src_q  <= eff_src;
      act_code_q <= eff_code;
      out_tick   <= 1'b0;
      if (eff_src == '0) begin
        cnt_q <= '0;
      end else if (sel_tick) begin
        if (cnt_q == eff_ratio - CNT_W'(1)) begin
          cnt_q    <= '0;
          out_tick <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_src == '0) |=> !out_tick); // R7
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && cfg_src != '0) |=> ($stable(act_src_q) && $stable(act_code_q))); // R10
  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    (act_src_q != '0) |-> (cnt_q < ratio_of(act_code_q, EXT_DIV))); // R5
  AST_TICK_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    out_tick |-> $past(aux_tick || (|gen_tick))); // R12

endmodule

// File: rtl/clk_consumer_sel.sv
module clk_consumer_sel
  import csel_pkg::*;
#(
  parameter int N_CONS  = 6,
  parameter int N_GEN   = 6,
  parameter bit EXT_DIV = 1'b0,
  localparam int REG_W  = N_CONS * FIELD_W,
  localparam int IDX_W  = (N_CONS > 1) ? $clog2(N_CONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [CNT_W-1:0]  cmd_ratio,
  input  logic              aux_tick,
  input  logic [N_GEN-1:0]  gen_tick,
  output logic [N_CONS-1:0] cons_tick,
  output logic [N_CONS-1:0] cons_en
);

  logic [REG_W-1:0] cfg_q;

  csel_regfile #(.N_CONS(N_CONS), .EXT_DIV(EXT_DIV)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_ratio (cmd_ratio),
    .cfg_q     (cfg_q),
    .en_q      (cons_en)
  );

  assign reg_rdata = cfg_q;

  for (genvar c = 0; c < N_CONS; c++) begin : g_cons
    csel_channel #(.N_GEN(N_GEN), .EXT_DIV(EXT_DIV)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .aux_tick (aux_tick),
      .gen_tick (gen_tick),
      .cfg_src  (cfg_q[c*FIELD_W+CODE_W +: SRC_W]),
      .cfg_code (cfg_q[c*FIELD_W +: CODE_W]),
      .out_tick (cons_tick[c])
    );
  end

endmodule

// File: tb/tb_clk_consumer_sel.sv
`timescale 1ns/1ps
module tb_clk_consumer_sel;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, cmd_valid = 1'b0, aux_tick = 1'b0;
  logic [29:0] reg_wdata = '0, rd0, rd1;
  logic [1:0] cmd_op = 2'd3;
  logic [2:0] cmd_idx = '0, cmd_ratio = '0;
  logic [5:0] gen_tick = '0, tk0, tk1, en0, en1;

  always #5 clk = ~clk;

  clk_consumer_sel #(.EXT_DIV(1'b0)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd0),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_ratio(cmd_ratio),
    .aux_tick(aux_tick), .gen_tick(gen_tick), .cons_tick(tk0), .cons_en(en0));

  clk_consumer_sel #(.EXT_DIV(1'b1)) dut_ext (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd1),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_ratio(cmd_ratio),
    .aux_tick(aux_tick), .gen_tick(gen_tick), .cons_tick(tk1), .cons_en(en1));

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit win_req = 0;
  int cnt_a [6];
  int cnt_b [6];
  logic [47:0] q_exp_a [$];
  logic [47:0] q_exp_b [$];
  string       q_tag   [$];

  function automatic void check(string req, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [47:0] p6(int c0, int c1, int c2, int c3, int c4, int c5);
    return {8'(c5), 8'(c4), 8'(c3), 8'(c2), 8'(c1), 8'(c0)};
  endfunction

  function automatic logic [4:0] fld(int src, int code);
    return {3'(src), 2'(code)};
  endfunction

  // Monitor: accumulates output ticks and scores a window when asked.
  always @(negedge clk) begin
    if (!rst)
      for (int c = 0; c < 6; c++) begin
        cnt_a[c] += int'(tk0[c]);
        cnt_b[c] += int'(tk1[c]);
      end
    if (win_req) begin
      logic [47:0] ea, eb;
      string t;
      ea = q_exp_a.pop_front();
      eb = q_exp_b.pop_front();
      t  = q_tag.pop_front();
      for (int c = 0; c < 6; c++) begin
        check(t, $sformatf("default consumer %0d tick count", c), cnt_a[c], ea[c*8 +: 8]);
        check(t, $sformatf("extended consumer %0d tick count", c), cnt_b[c], eb[c*8 +: 8]);
        cnt_a[c] = 0;
        cnt_b[c] = 0;
      end
      win_req = 0;
    end
  end

  task automatic close_window(string tag, logic [47:0] ea, logic [47:0] eb);
    repeat (3) @(negedge clk);
    q_exp_a.push_back(ea);
    q_exp_b.push_back(eb);
    q_tag.push_back(tag);
    #1 win_req = 1;
    wait (win_req == 0);
  endtask

  task automatic pulse(logic a, logic [5:0] gm);
    @(negedge clk);
    aux_tick = a;
    gen_tick = gm;
    @(negedge clk);
    aux_tick = 1'b0;
    gen_tick = '0;
  endtask

  task automatic run(int n, logic a, logic [5:0] gm);
    for (int i = 0; i < n; i++) pulse(a, gm);
  endtask

  task automatic issue(bit we, logic [29:0] w, bit cv, int op, int idx, int r);
    @(negedge clk);
    reg_we = we; reg_wdata = w;
    cmd_valid = cv; cmd_op = 2'(op); cmd_idx = 3'(idx); cmd_ratio = 3'(r);
    @(negedge clk);
    reg_we = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  logic [29:0] W, W2;

  initial begin
    W = {fld(7,3), fld(0,0), fld(4,2), fld(3,3), fld(2,1), fld(1,0)};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset register", rd0, 0);
    check("R6", "reset enables", en0, 0);
    check("R12", "reset ticks", tk0, 0);

    issue(0, '0, 1, 1, 4, 0);
    check("R8", "on after reset picks source 1", rd0, 30'(1) << 22);
    check("R6", "enable after on", en0, 6'b010000);
    issue(0, '0, 1, 0, 4, 0);
    check("R7", "off clears source", rd0, 0);

    issue(1, W, 0, 0, 0, 0);
    check("R1", "read back default", rd0, W);
    check("R1", "read back extended", rd1, W);
    check("R6", "enables follow sources", en0, 6'b101111);
    run(12, 1'b1, 6'b111111);
    close_window("R3 R4 R5 all sources", p6(12,3,6,12,0,6), p6(12,3,6,4,0,6));
    run(12, 1'b0, 6'b100000);
    close_window("R2 generator 5 only", p6(0,0,0,0,0,6), p6(0,0,0,0,0,6));
    run(12, 1'b1, 6'b000000);
    close_window("R2 aux only", p6(12,0,0,0,0,0), p6(12,0,0,0,0,0));

    pulse(1'b1, 6'b000000);
    check("R12", "tick one clock after input", tk0[0], 1);
    @(negedge clk);
    check("R12", "tick lasts one clock", tk0[0], 0);
    close_window("R12 single", p6(1,0,0,0,0,0), p6(1,0,0,0,0,0));

    run(2, 1'b0, 6'b000001);
    issue(1, W & ~(30'h3 << 5), 0, 0, 0, 0);
    run(6, 1'b0, 6'b000001);
    close_window("R10 mid-period change", p6(0,5,0,0,0,0), p6(0,5,0,0,0,0));
    issue(1, W, 0, 0, 0, 0);

    run(2, 1'b0, 6'b000001);
    issue(0, '0, 1, 0, 1, 0);
    check("R7", "off drops enable", en0[1], 0);
    check("R7", "off clears field source", rd0[9:7], 0);
    run(4, 1'b0, 6'b000001);
    close_window("R7 quiet while off", p6(0,0,0,0,0,0), p6(0,0,0,0,0,0));
    issue(0, '0, 1, 1, 1, 0);
    check("R8", "on restores source and code", rd0, W);
    run(6, 1'b0, 6'b000001);
    close_window("R7 count restarted", p6(0,1,0,0,0,0), p6(0,1,0,0,0,0));
    run(2, 1'b0, 6'b000001);
    close_window("R7 period finish", p6(0,1,0,0,0,0), p6(0,1,0,0,0,0));

    W2 = (W & ~30'h1F) | 30'(fld(3,0));
    issue(1, W2, 1, 0, 0, 0);
    check("R11", "off beats write", rd0, W2 & ~(30'h7 << 2));
    issue(1, W2, 1, 1, 0, 0);
    check("R11", "on beats write", rd0, W);
    issue(1, W, 1, 2, 2, 4);
    check("R11", "ratio beats write", rd0, (W & ~(30'h3 << 10)) | (30'h1 << 10));
    issue(1, W, 0, 0, 0, 0);

    issue(0, '0, 1, 2, 3, 3);
    check("R9", "ratio 3 default code", rd0[16:15], 1);
    check("R9", "ratio 3 extended code", rd1[16:15], 2);
    run(12, 1'b0, 6'b000100);
    close_window("R9 ratio 3 request", p6(0,0,0,3,0,0), p6(0,0,0,4,0,0));
    issue(0, '0, 1, 2, 3, 7);
    check("R9", "invalid ratio ignored", rd0[16:15], 1);
    check("R9", "invalid ratio ignored ext", rd1[16:15], 2);
    issue(0, '0, 1, 3, 3, 1);
    check("R9", "no-op command", rd0[16:15], 1);
    issue(0, '0, 1, 2, 3, 2);
    check("R9", "ratio 2", rd0[16:15], 3);
    issue(0, '0, 1, 2, 3, 1);
    check("R9", "ratio 1", rd1[16:15], 0);
    issue(0, '0, 1, 2, 3, 4);
    check("R9", "ratio 4", rd1[16:15], 1);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule